// File: doc/BRIEF.md
# Bus Recovery Delay Arbiter

This block decides how many idle clock cycles must separate two consecutive accesses on an external bus. When an access is accepted, the block records its direction and target region. After that access ends, the block holds back the next access request until enough cycles have elapsed. It sizes the gap from four per-region timing fields, a clock multiplier and a two-bit multiplier-enable selection.

Four candidate delays are considered. The first is a recovery count after a read and the second a recovery count after a write; both come from the region of the previous access. The third is a turnaround count, which applies when the direction flips. The fourth is a region-change count, which applies when the next access targets another region. Only the candidates whose condition holds take part, and the largest of them is the gap. The turnaround and region-change counts are always scaled by the multiplier. The read and write recovery counts are scaled only when their own enable bit is set.

New accesses enter through a valid/ready handshake. A requester raises `req_valid` with the direction and region and keeps them stable until `req_ready` is seen high at a clock edge. `req_ready` stays low while an access is in flight and while the gap has not yet elapsed. The sequencer that drives the bus reports the end of each access with a one-cycle `acc_done` pulse.

Top module: `recov_gap_ctl`

## Requirements
- R1: After reset no access is recorded. With no access in flight, the first request is accepted in the cycle it is presented, whatever the timing fields hold.
- R2: A handshake (`req_valid` and `req_ready` high at a rising edge) starts an access. `req_ready` stays low from then until the edge that samples `acc_done`. An `acc_done` pulse while no access is in flight has no effect.
- R3: Let E be the cycle in which `acc_done` ends an access and G the computed gap. The next request can be accepted no earlier than cycle E+1+G, so G = 0 allows acceptance in cycle E+1. Idle cycles keep counting toward G even when no request is waiting. A count that has passed 240 saturates, so a long idle period always satisfies any gap.
- R4: If the previous access was a read (`req_write` = 0), its region's read recovery field is a candidate. The field is multiplied only when `mult_en[5]` = 1.
- R5: If the previous access was a write (`req_write` = 1), its region's write recovery field is a candidate. The field is multiplied only when `mult_en[6]` = 1.
- R6: If the next direction differs from the previous one, the previous region's turnaround field, always multiplied, is a candidate.
- R7: If the next region differs from the previous one, the previous region's region-change field, always multiplied, is a candidate.
- R8: The gap is the largest applicable candidate, and zero when every applicable field is zero.
- R9: `mult_code` selects the multiplier: 2'b00 = ×1, 2'b01 = ×4, 2'b10 = ×8, 2'b11 = ×16. Region k's 4-bit fields sit at bits [4k+3:4k] of each field bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Next access is presented |
| req_ready | output | 1 | Next access may start at this edge |
| req_write | input | 1 | Direction of presented access: 1 = write, 0 = read |
| req_region | input | 2 | Region of presented access |
| acc_done | input | 1 | One-cycle pulse: the access in flight has ended |
| rd_rec | input | 16 | Read recovery fields, 4 bits per region |
| wr_rec | input | 16 | Write recovery fields, 4 bits per region |
| turn_rec | input | 16 | Direction turnaround fields, 4 bits per region |
| xreg_rec | input | 16 | Region-change fields, 4 bits per region |
| mult_code | input | 2 | Multiplier selection code |
| mult_en | input | 7 | Multiplier enable map; bit 5 scales read recovery, bit 6 scales write recovery |

## Verification
The hardest situations to reach from the ports are the idle-time cases. One is an `acc_done` that arrives with no access in flight; the other is a wait so long that the elapsed count saturates. Both are invisible unless a later request shows whether its gap was wrongly restarted. The bench therefore lets a nonzero gap run out before it pulses `acc_done` while idle, then presents a request and expects immediate acceptance. It also idles several hundred cycles before a request whose gap is 144 cycles. The table walk drives each candidate to be the winning one in turn, with every multiplier code and both enable bits set and cleared.

// File: rtl/rgap_pkg.sv
package rgap_pkg;
  localparam int unsigned NUM_CAND      = 4;
  localparam int unsigned MUL_SHIFT_MAX = 4;
  localparam int unsigned EN_MAP_W      = 7;
  localparam int unsigned EN_BIT_RD     = 5;
  localparam int unsigned EN_BIT_WR     = 6;

  typedef enum logic [1:0] {
    CK_RD   = 2'd0,
    CK_WR   = 2'd1,
    CK_TURN = 2'd2,
    CK_XREG = 2'd3
  } cand_kind_e;

  typedef enum logic [1:0] {
    MUL_X1  = 2'b00,
    MUL_X4  = 2'b01,
    MUL_X8  = 2'b10,
    MUL_X16 = 2'b11
  } mul_code_e;

  function automatic logic [2:0] mul_shift(input logic [1:0] code);
    case (mul_code_e'(code))
      MUL_X1:  return 3'd0;
      MUL_X4:  return 3'd2;
      MUL_X8:  return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rgap_cand.sv
module rgap_cand
  import rgap_pkg::*;
#(
  parameter int unsigned PW = 4,
  localparam int unsigned CW = PW + MUL_SHIFT_MAX
) (
  input  logic                            prev_write,
  input  logic                            next_write,
  input  logic                            region_chg,
  input  logic [PW-1:0]                   fld_rd,
  input  logic [PW-1:0]                   fld_wr,
  input  logic [PW-1:0]                   fld_turn,
  input  logic [PW-1:0]                   fld_xreg,
  input  logic [1:0]                      mult_code,
  input  logic                            scale_rd,
  input  logic                            scale_wr,
  output logic [NUM_CAND-1:0][CW-1:0]     cand
);
  logic [PW-1:0]       raw      [NUM_CAND];
  logic [NUM_CAND-1:0] applies;
  logic [NUM_CAND-1:0] scale_on;
  logic [2:0]          sh;

  always_comb begin
    sh                = mul_shift(mult_code);
    raw[CK_RD]        = fld_rd;
    raw[CK_WR]        = fld_wr;
    raw[CK_TURN]      = fld_turn;
    raw[CK_XREG]      = fld_xreg;
    applies[CK_RD]    = !prev_write;
    applies[CK_WR]    = prev_write;
    applies[CK_TURN]  = prev_write != next_write;
    applies[CK_XREG]  = region_chg;
    scale_on[CK_RD]   = scale_rd;
    scale_on[CK_WR]   = scale_wr;
    scale_on[CK_TURN] = 1'b1;
    scale_on[CK_XREG] = 1'b1;
  end

  for (genvar k = 0; k < NUM_CAND; k++) begin : g_cand
    logic [CW-1:0] wide;
    logic [CW-1:0] scaled;
    assign wide    = {{(CW-PW){1'b0}}, raw[k]};
    assign scaled  = scale_on[k] ? (wide << sh) : wide;
    assign cand[k] = applies[k] ? scaled : '0;
  end
endmodule

// File: rtl/rgap_max.sv
module rgap_max #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0][W-1:0] din,
  output logic [W-1:0]        dmax
);
  always_comb begin
    dmax = '0;
    for (int i = 0; i < N; i++) begin
      if (din[i] > dmax) dmax = din[i];
    end
  end
endmodule

// File: rtl/rgap_timer.sv
module rgap_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          count_en,
  output logic [CW-1:0] elapsed
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (restart) begin
      elapsed <= '0;
    end else if (count_en && elapsed != TOP) begin
      elapsed <= elapsed + 1'b1;
    end
  end
endmodule

// File: rtl/recov_gap_ctl.sv
module recov_gap_ctl
  import rgap_pkg::*;
#(
  parameter int unsigned NREG = 4,
  parameter int unsigned PW   = 4,
  localparam int unsigned RW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned FW  = NREG * PW,
  localparam int unsigned CW  = PW + MUL_SHIFT_MAX
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [RW-1:0]       req_region,
  input  logic                acc_done,
  input  logic [FW-1:0]       rd_rec,
  input  logic [FW-1:0]       wr_rec,
  input  logic [FW-1:0]       turn_rec,
  input  logic [FW-1:0]       xreg_rec,
  input  logic [1:0]          mult_code,
  input  logic [EN_MAP_W-1:0] mult_en
);
  logic          busy_q;
  logic          has_prev_q;
  logic          prev_write_q;
  logic [RW-1:0] prev_region_q;
  logic          accept;
  logic          closing;

  logic [PW-1:0] rd_a   [NREG];
  logic [PW-1:0] wr_a   [NREG];
  logic [PW-1:0] turn_a [NREG];
  logic [PW-1:0] xreg_a [NREG];

  logic [NUM_CAND-1:0][CW-1:0] cand_w;
  logic [CW-1:0]               gap_w;
  logic [CW-1:0]               elapsed_w;
  logic                        unused_map_bits;

  for (genvar g = 0; g < NREG; g++) begin : g_split
    assign rd_a[g]   = rd_rec[g*PW +: PW];
    assign wr_a[g]   = wr_rec[g*PW +: PW];
    assign turn_a[g] = turn_rec[g*PW +: PW];
    assign xreg_a[g] = xreg_rec[g*PW +: PW];
  end

  assign unused_map_bits = ^mult_en[EN_BIT_RD-1:0];

  rgap_cand #(.PW(PW)) u_cand (
    .prev_write (prev_write_q),
    .next_write (req_write),
    .region_chg (req_region != prev_region_q),
    .fld_rd     (rd_a[prev_region_q]),
    .fld_wr     (wr_a[prev_region_q]),
    .fld_turn   (turn_a[prev_region_q]),
    .fld_xreg   (xreg_a[prev_region_q]),
    .mult_code  (mult_code),
    .scale_rd   (mult_en[EN_BIT_RD]),
    .scale_wr   (mult_en[EN_BIT_WR]),
    .cand       (cand_w)
  );

  rgap_max #(.N(NUM_CAND), .W(CW)) u_max (
    .din  (cand_w),
    .dmax (gap_w)
  );

  rgap_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (closing),
    .count_en (!busy_q),
    .elapsed  (elapsed_w)
  );

  assign req_ready = !busy_q && (!has_prev_q || elapsed_w >= gap_w);
  assign accept    = req_valid && req_ready;
  assign closing   = busy_q && acc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q        <= 1'b0;
      has_prev_q    <= 1'b0;
      prev_write_q  <= 1'b0;
      prev_region_q <= '0;
    end else if (accept) begin
      busy_q        <= 1'b1;
      has_prev_q    <= 1'b1;
      prev_write_q  <= req_write;
      prev_region_q <= req_region;
    end else if (closing) begin
      busy_q        <= 1'b0;
    end
  end
endmodule

// File: rtl/recov_gap_ctl_chk.sv
module recov_gap_ctl_chk #(
  parameter int unsigned NC = 4,
  parameter int unsigned CW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  acc_done,
  input logic                  busy_q,
  input logic                  has_prev_q,
  input logic [NC-1:0][CW-1:0] cand_w,
  input logic [CW-1:0]         gap_w
);
  // R1
  first_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_prev_q && !busy_q) |-> req_ready);

  // R2
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !req_ready);

  // R2
  start_by_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(req_valid && req_ready));

  // R2
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && acc_done && !(req_valid && req_ready)) |=> !busy_q);

  // R3
  zero_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && acc_done) |=> (gap_w != '0 || req_ready));

  // R8
  for (genvar k = 0; k < NC; k++) begin : g_floor
    gap_covers_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap_w >= cand_w[k]);
  end
endmodule

bind recov_gap_ctl recov_gap_ctl_chk #(.NC(rgap_pkg::NUM_CAND), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .acc_done   (acc_done),
  .busy_q     (busy_q),
  .has_prev_q (has_prev_q),
  .cand_w     (cand_w),
  .gap_w      (gap_w)
);

// File: tb/recov_gap_ctl_tb.sv
module recov_gap_ctl_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       pw;
    logic [1:0] pr;
    logic       nw;
    logic [1:0] nr;
    logic [1:0] code;
    logic       e5;
    logic       e6;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 8'd3},
    '{1'b1, 2'd0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 8'd5},
    '{1'b0, 2'd0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 8'd3},
    '{1'b0, 2'd1, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 8'd6},
    '{1'b0, 2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 8'd4},
    '{1'b0, 2'd2, 1'b0, 2'd2, 2'd3, 1'b1, 1'b1, 8'd0},
    '{1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 8'd3},
    '{1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 8'd12},
    '{1'b1, 2'd0, 1'b1, 2'd0, 2'd2, 1'b0, 1'b1, 8'd40},
    '{1'b1, 2'd0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 8'd5},
    '{1'b0, 2'd3, 1'b1, 2'd2, 2'd3, 1'b0, 1'b0, 8'd144},
    '{1'b1, 2'd1, 1'b0, 2'd3, 2'd1, 1'b0, 1'b1, 8'd24},
    '{1'b0, 2'd2, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 8'd0},
    '{1'b1, 2'd3, 1'b1, 2'd3, 2'd2, 1'b0, 1'b1, 8'd8},
    '{1'b0, 2'd3, 1'b0, 2'd3, 2'd2, 1'b1, 1'b0, 8'd56},
    '{1'b1, 2'd1, 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 8'd64}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_region = '0;
  logic        acc_done = 1'b0;
  logic [15:0] rd_rec   = 16'h7013;
  logic [15:0] wr_rec   = 16'h1025;
  logic [15:0] turn_rec = 16'h3062;
  logic [15:0] xreg_rec = 16'h9041;
  logic [1:0]  mult_code = 2'd0;
  logic [6:0]  mult_en = '0;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  recov_gap_ctl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_region (req_region),
    .acc_done   (acc_done),
    .rd_rec     (rd_rec),
    .wr_rec     (wr_rec),
    .turn_rec   (turn_rec),
    .xreg_rec   (xreg_rec),
    .mult_code  (mult_code),
    .mult_en    (mult_en)
  );

  function automatic string vtag(input int i);
    case (i)
      1, 8:    return "R5";
      3:       return "R6";
      4:       return "R7";
      5, 12:   return "R3";
      6, 7:    return "R4";
      9:       return "R5";
      10, 11:  return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic config_mult(input logic [1:0] code, input logic e5, input logic e6);
    mult_code = code;
    mult_en   = {e6, e5, 5'b0};
  endtask

  // Called at a negedge; returns at the negedge after acceptance.
  task automatic issue(input logic w, input logic [1:0] r, output int waited);
    req_write  = w;
    req_region = r;
    req_valid  = 1'b1;
    waited     = 0;
    while (!req_ready && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic end_access();
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: ready out of reset, first access not delayed
    check("R1 ready after reset", int'(req_ready), 1);
    issue(1'b1, 2'd3, w);
    check("R1 first access wait", w, 0);

    // R2: ready held low during access even with valid high
    req_valid = 1'b1; req_write = 1'b0; req_region = 2'd3;
    for (int i = 0; i < 3; i++) begin
      check("R2 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    end_access();

    for (int i = 0; i < NV; i++) begin
      config_mult(VECS[i].code, VECS[i].e5, VECS[i].e6);
      issue(VECS[i].pw, VECS[i].pr, w);
      repeat (2) @(negedge clk);
      end_access();
      issue(VECS[i].nw, VECS[i].nr, w);
      check(vtag(i), w, int'(VECS[i].exp));
      end_access();
    end

    // R2: acc_done while idle must not restart the gap (prev W0, gap W0->W0 = 5)
    config_mult(2'd3, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    end_access();
    issue(1'b1, 2'd0, w);
    check("R2 idle acc_done ignored", w, 0);
    end_access();

    // R3: long idle saturates and satisfies a 144-cycle gap
    issue(1'b0, 2'd3, w);
    end_access();
    repeat (300) @(negedge clk);
    issue(1'b1, 2'd2, w);
    check("R3 saturated idle count", w, 0);
    end_access();

    // R1: reset mid-run forgets the previous access
    issue(1'b0, 2'd3, w);
    end_access();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1'b1, 2'd2, w);
    check("R1 first access after second reset", w, 0);
    end_access();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule